// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block watches the two correction pulses of a phase-frequency detector and raises an active-high lock flag once the loop has settled. A fast sampling clock measures each comparison cycle. While a pulse is high, a counter for that pulse advances once per sampling edge. The phase error of the cycle is the larger of the two counts. A strobe from the reference divider closes each comparison cycle.

Lock is gained only after a run of consecutive small-error cycles. The run is 3 or 5 cycles long, chosen by a select input. Lock is lost as soon as a single cycle shows an error above a second, larger limit. Errors that fall between the two limits leave a held lock unchanged, which gives the detector hysteresis. A synchronous clear input lets power-down or counter-reset logic return the detector to its idle state.

Both limits are given in nanoseconds and turned into sample counts from the sampling period. With the default parameters the set limit is 15 counts and the clear limit is 25 counts.

Top module: `pfd_lock_detect`

## Requirements
- R1: After reset, `lock_out` is 0.
- R2: The error of a cycle is the larger of two counts: the sampling edges with `up_pulse` high and the sampling edges with `dn_pulse` high. Both counts cover the edges since the previous strobe edge. A sample taken at a strobe edge belongs to the next cycle.
- R3: With `long_run_sel`=0, `lock_out` rises at the strobe edge that ends the third consecutive good cycle. A good cycle has an error below 15.
- R4: With `long_run_sel`=1, `lock_out` rises at the strobe edge that ends the fifth consecutive good cycle.
- R5: While unlocked, any cycle that is not good resets the run of good cycles to zero.
- R6: While locked, a cycle with an error above 25 drops `lock_out` at its strobe edge.
- R7: While locked, a cycle with an error from 15 to 25 inclusive leaves `lock_out` at 1.
- R8: A cycle in which neither pulse is seen has error 0 and counts as good.
- R9: `det_clear`=1 drops `lock_out` at the next edge and empties the run of good cycles.
- R10: `lock_out` changes only at an edge where `ref_strobe` or `det_clear` is high.
- R11: The limits are exact. An error of 14 is good and an error of 15 is not. An error of 25 keeps lock and an error of 26 drops it.
- R12: When both pulses are active in the same cycle, the longer pulse sets the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_pulse | input | 1 | Up pulse from the phase detector |
| dn_pulse | input | 1 | Down pulse from the phase detector |
| ref_strobe | input | 1 | One-cycle strobe that ends a comparison cycle |
| long_run_sel | input | 1 | 0: 3 good cycles to lock, 1: 5 good cycles |
| det_clear | input | 1 | Synchronous clear from power-down or counter reset |
| lock_out | output | 1 | Lock flag, active high |

## Verification
Each lock decision is made at the sampling edge that sees `ref_strobe` high and is visible from that edge onwards. A clear takes effect at the edge that sees `det_clear`. The bench drives inputs on falling edges and reads `lock_out` on the falling edge after the strobe or clear, which is half a period after the deciding edge. A pulse held high for w falling-edge intervals spans exactly w rising edges, so each cycle's error is known exactly before the strobe is issued.

// File: rtl/ld_pkg.sv
package ld_pkg;
   typedef enum logic [1:0] {
      ERR_GOOD = 2'd0,
      ERR_MID  = 2'd1,
      ERR_BAD  = 2'd2
   } err_class_e;
endpackage

// File: rtl/pulse_width_meter.sv
module pulse_width_meter #(
   parameter int SAT = 26,
   parameter int W   = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         restart,
   input  logic         pulse,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] SAT_V = W'(SAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (restart)
         cnt <= pulse ? W'(1) : '0;
      else if (pulse && cnt != SAT_V)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/error_classifier.sv
module error_classifier
   import ld_pkg::*;
#(
   parameter int W       = 5,
   parameter int SET_CNT = 15,
   parameter int CLR_CNT = 25
) (
   input  logic [W-1:0] cnt_up,
   input  logic [W-1:0] cnt_dn,
   output err_class_e   cls
);
   localparam logic [W-1:0] SET_V = W'(SET_CNT);
   localparam logic [W-1:0] CLR_V = W'(CLR_CNT);

   logic [W-1:0] worst;

   always_comb begin
      worst = (cnt_up > cnt_dn) ? cnt_up : cnt_dn;
      if (worst < SET_V)
         cls = ERR_GOOD;
      else if (worst > CLR_V)
         cls = ERR_BAD;
      else
         cls = ERR_MID;
   end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
   import ld_pkg::*;
#(
   parameter int RUN_SHORT = 3,
   parameter int RUN_LONG  = 5,
   parameter int RUN_W     = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       strobe,
   input  logic       long_sel,
   input  err_class_e cls,
   output logic       locked
);
   logic [RUN_W-1:0] run;
   logic [RUN_W-1:0] need;
   logic [RUN_W-1:0] run_nxt;

   assign need    = long_sel ? RUN_W'(RUN_LONG) : RUN_W'(RUN_SHORT);
   assign run_nxt = run + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
         run    <= '0;
      end else if (clr) begin
         locked <= 1'b0;
         run    <= '0;
      end else if (strobe) begin
         if (!locked) begin
            if (cls == ERR_GOOD) begin
               if (run_nxt >= need) begin
                  locked <= 1'b1;
                  run    <= '0;
               end else begin
                  run <= run_nxt;
               end
            end else begin
               run <= '0;
            end
         end else if (cls == ERR_BAD) begin
            locked <= 1'b0;
            run    <= '0;
         end
      end
   end
endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
   import ld_pkg::*;
#(
   parameter int SAMPLE_PS = 1000,
   parameter int SET_NS    = 15,
   parameter int CLR_NS    = 25,
   parameter int RUN_SHORT = 3,
   parameter int RUN_LONG  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up_pulse,
   input  logic dn_pulse,
   input  logic ref_strobe,
   input  logic long_run_sel,
   input  logic det_clear,
   output logic lock_out
);
   localparam int SET_CNT = (SET_NS * 1000) / SAMPLE_PS;
   localparam int CLR_CNT = (CLR_NS * 1000) / SAMPLE_PS;
   localparam int SAT     = CLR_CNT + 1;
   localparam int CNT_W   = $clog2(SAT + 1);
   localparam int RUN_W   = $clog2(RUN_LONG + 1);
   localparam int NCH     = 2;

   if (SET_CNT < 1) begin : g_bad_set
      $error("set limit must be at least one sample period");
   end
   if (CLR_CNT < SET_CNT) begin : g_bad_clr
      $error("clear limit must not be below set limit");
   end
   if (RUN_SHORT < 1 || RUN_LONG < RUN_SHORT) begin : g_bad_run
      $error("run lengths must satisfy 1 <= short <= long");
   end

   logic [NCH-1:0]   pulses;
   logic [CNT_W-1:0] widths [NCH];
   err_class_e       cls;

   assign pulses = {dn_pulse, up_pulse};

   for (genvar i = 0; i < NCH; i++) begin : g_meter
      pulse_width_meter #(.SAT(SAT), .W(CNT_W)) u_meter (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (det_clear),
         .restart (ref_strobe),
         .pulse   (pulses[i]),
         .cnt     (widths[i])
      );
   end

   error_classifier #(.W(CNT_W), .SET_CNT(SET_CNT), .CLR_CNT(CLR_CNT)) u_cls (
      .cnt_up (widths[0]),
      .cnt_dn (widths[1]),
      .cls    (cls)
   );

   lock_fsm #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG), .RUN_W(RUN_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (det_clear),
      .strobe   (ref_strobe),
      .long_sel (long_run_sel),
      .cls      (cls),
      .locked   (lock_out)
   );
endmodule

// File: rtl/ld_checker.sv
module ld_checker
   import ld_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       ref_strobe,
   input logic       det_clear,
   input logic       lock_out,
   input err_class_e cls
);
   p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_strobe && !det_clear) |=> $stable(lock_out));

   p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      det_clear |=> !lock_out);

   p_bad_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_strobe && lock_out && cls == ERR_BAD) |=> !lock_out);

   p_mid_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_strobe && !det_clear && lock_out && cls != ERR_BAD) |=> lock_out);

   p_rise_needs_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_strobe && !lock_out && cls != ERR_GOOD) |=> !lock_out);

   p_class_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cls != 2'd3);
endmodule

bind pfd_lock_detect ld_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_strobe (ref_strobe),
   .det_clear  (det_clear),
   .lock_out   (lock_out),
   .cls        (cls)
);

// File: tb/tb_pfd_lock_detect.sv
`timescale 1ns/1ps
module tb_pfd_lock_detect;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_pulse = 1'b0, dn_pulse = 1'b0, ref_strobe = 1'b0;
   logic long_run_sel = 1'b0, det_clear = 1'b0;
   logic lock_out;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   pfd_lock_detect dut (
      .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
      .ref_strobe(ref_strobe), .long_run_sel(long_run_sel),
      .det_clear(det_clear), .lock_out(lock_out)
   );

   task automatic check(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: lock_out=%b expected %b", req, got, exp);
      end
   endtask

   // one comparison cycle: pulses start together, then idle, then strobe
   task automatic cycle(input int up_w, input int dn_w, input bit strobe = 1'b1);
      int span = (up_w > dn_w) ? up_w : dn_w;
      for (int k = 0; k < span; k++) begin
         @(negedge clk);
         up_pulse = (k < up_w);
         dn_pulse = (k < dn_w);
      end
      @(negedge clk);
      up_pulse = 1'b0;
      dn_pulse = 1'b0;
      @(negedge clk);
      if (strobe) begin
         ref_strobe = 1'b1;
         @(negedge clk);
         ref_strobe = 1'b0;
      end
   endtask

   task automatic unlock();
      cycle(40, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 reset", lock_out, 1'b0);
   endtask

   task automatic t_lock_short();
      long_run_sel = 1'b0;
      cycle(0, 0); check("R3/R8 after 1 idle cycle", lock_out, 1'b0);
      cycle(0, 0); check("R3/R8 after 2 idle cycles", lock_out, 1'b0);
      cycle(0, 0); check("R3/R8 lock after 3", lock_out, 1'b1);
   endtask

   task automatic t_hysteresis();
      cycle(25, 0); check("R7/R11 error 25 keeps lock", lock_out, 1'b1);
      cycle(0, 15); check("R7/R11 error 15 keeps lock", lock_out, 1'b1);
      cycle(26, 0); check("R6/R11 error 26 drops lock", lock_out, 1'b0);
   endtask

   task automatic t_lock_long();
      long_run_sel = 1'b1;
      for (int i = 0; i < 4; i++) cycle(14, 3);
      check("R4/R11 not locked after 4 of 5", lock_out, 1'b0);
      cycle(14, 0); check("R4 locked after 5", lock_out, 1'b1);
      unlock();
   endtask

   task automatic t_run_reset();
      long_run_sel = 1'b1;
      for (int i = 0; i < 3; i++) cycle(5, 0);
      cycle(15, 0); check("R5/R11 error 15 breaks run", lock_out, 1'b0);
      for (int i = 0; i < 4; i++) cycle(0, 7);
      check("R5 run restarted, 4 good not enough", lock_out, 1'b0);
      cycle(2, 2); check("R5 locks after 5 fresh good", lock_out, 1'b1);
   endtask

   task automatic t_overlap();
      cycle(5, 30); check("R12/R2 longer down pulse drops lock", lock_out, 1'b0);
   endtask

   task automatic t_clear();
      long_run_sel = 1'b0;
      cycle(0, 0);
      cycle(0, 0);
      @(negedge clk); det_clear = 1'b1;
      @(negedge clk); det_clear = 1'b0;
      cycle(0, 0);
      cycle(0, 0); check("R9 run emptied by clear", lock_out, 1'b0);
      cycle(0, 0); check("R9 relock after 3 fresh", lock_out, 1'b1);
      @(negedge clk); det_clear = 1'b1;
      @(negedge clk); det_clear = 1'b0;
      check("R9 clear drops lock", lock_out, 1'b0);
   endtask

   task automatic t_no_strobe();
      long_run_sel = 1'b0;
      for (int i = 0; i < 3; i++) cycle(0, 0);
      cycle(40, 40, 1'b0);
      check("R10 no strobe, lock held", lock_out, 1'b1);
      @(negedge clk); ref_strobe = 1'b1;
      @(negedge clk); ref_strobe = 1'b0;
      check("R10/R2 strobe ends long cycle", lock_out, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lock_short();
      t_hysteresis();
      t_lock_long();
      t_run_reset();
      t_overlap();
      t_clear();
      t_no_strobe();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule